// File: doc/BRIEF.md
# Interleaved I/Q Bus Splitter

This block accepts one parallel sample bus that carries I and Q words one after the other. It splits the stream into two time-aligned output channels, A and B, on the rising edge of the data clock. Each output channel then runs at half the input word rate. A pair strobe rises for one cycle each time a complete A/B pair reaches the outputs. Both outputs change together in that cycle and hold their values at all other times.

A configuration bit selects how the channel phase is set. In transmit-enable sync, the first word sampled while the enable is high goes to A, and later words alternate B, A, B. Dropping the enable stops capture and resets the phase. In flag sync, a per-word flag input names the channel of each word and the enable input has no effect. A second configuration bit turns interleaving off. In that case both outputs are registered copies of two separate input buses, and the strobe is held high.

Top module: `iq_bus_splitter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_a`, `out_b` and `pair_vld` are cleared to 0 at that edge, and no A word stays pending.
- R2: With `cfg_interleave` = 0, each edge loads `out_a` from `bus_a` and `out_b` from `bus_b` and drives `pair_vld` to 1. Any pending A word is discarded.
- R3: In transmit-enable sync (`cfg_interleave` = 1, `cfg_flag_sync` = 0), the first edge with `tx_en` high captures `bus_a` as an A word and produces no pair. The next edge with `tx_en` still high takes `bus_a` as the B word. At that edge `out_a` gets the A word, `out_b` gets the B word and `pair_vld` = 1.
- R4: Over a run of edges with `tx_en` high, words 0, 2, 4… are A and words 1, 3, 5… are B. `pair_vld` is 1 after every second edge of the run and is never 1 after two edges in a row.
- R5: At an edge with `tx_en` low in transmit-enable sync, no word is captured, `pair_vld` goes to 0, and the outputs hold. A pending A word is dropped, so the next high run starts again at A.
- R6: In flag sync (`cfg_interleave` = 1, `cfg_flag_sync` = 1), a word with `word_flag` = 0 is an A word and produces no pair. A word with `word_flag` = 1 that follows a pending A word completes a pair. On that pair, `out_a` gets the A word, `out_b` gets the B word and `pair_vld` = 1.
- R7: In flag sync, an A word that arrives while another A word is pending replaces it.
- R8: In flag sync, a B word with no pending A word is dropped: `pair_vld` = 0 and the outputs hold.
- R9: In flag sync, `tx_en` has no effect on capture or output.
- R10: Whenever `pair_vld` is 0, `out_a` and `out_b` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_interleave | input | 1 | 1: split the interleaved stream on `bus_a`; 0: two-bus pass-through |
| cfg_flag_sync | input | 1 | 1: phase from `word_flag`; 0: phase from `tx_en` |
| tx_en | input | 1 | Transmit enable; a high run marks a burst that starts with an A word |
| word_flag | input | 1 | Per-word channel flag in flag sync: 1 = B, 0 = A |
| bus_a | input | 16 | Interleaved word input, or the A input in pass-through |
| bus_b | input | 16 | B input, used only in pass-through |
| out_a | output | 16 | Channel A sample |
| out_b | output | 16 | Channel B sample |
| pair_vld | output | 1 | High for one cycle when a new A/B pair is on the outputs; held high in pass-through |

## Verification
The bench first runs the pass-through path with distinct counting words on each bus. This separates the two buses and exposes any one-cycle skew. It then drives transmit-enable bursts of every length from 1 to 9, with unrelated words on the bus between bursts. The odd lengths show whether a leftover A word is dropped, and the gaps show whether capture stops and the outputs hold. Last, it drives every 6-word flag sequence (64 of them) while `tx_en` toggles. This covers A-then-B pairing, A words that replace a pending A word, lone B words that must be dropped, and any unwanted effect of `tx_en`.

// File: rtl/iq_split_pkg.sv
// Package: shared types for the interleaved I/Q bus splitter.
// Assumes: three operating modes, decoded from two configuration bits.
package iq_split_pkg;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_TXEN = 2'd1,
        MODE_FLAG = 2'd2
    } split_mode_e;

    // Decode the two configuration bits into an operating mode.
    function automatic split_mode_e pick_mode(input logic interleave, input logic flag_sync);
        if (!interleave)
            return MODE_PASS;
        else if (flag_sync)
            return MODE_FLAG;
        else
            return MODE_TXEN;
    endfunction

endpackage

// File: rtl/iq_phase_ctl.sv
// Module: iq_phase_ctl
// Tracks whether an A word is waiting for its B partner. Each cycle it
// decides whether to load the A holding register and whether to emit a pair.
// Assumes: synchronous active-low reset; the mode comes from iq_split_pkg.
module iq_phase_ctl
    import iq_split_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  split_mode_e mode,
    input  logic        tx_en,
    input  logic        word_flag,
    output logic        load_a,
    output logic        emit_pair
);

    logic a_pending;
    logic a_pending_nxt;

    // Next-state and strobe decode for the pending-A tracker.
    always_comb begin
        load_a        = 1'b0;
        emit_pair     = 1'b0;
        a_pending_nxt = 1'b0;
        unique case (mode)
            MODE_TXEN: begin
                if (tx_en) begin
                    load_a        = !a_pending;
                    emit_pair     = a_pending;
                    a_pending_nxt = !a_pending;
                end
            end
            MODE_FLAG: begin
                if (!word_flag) begin
                    load_a        = 1'b1;
                    a_pending_nxt = 1'b1;
                end else begin
                    emit_pair     = a_pending;
                end
            end
            default: begin
                a_pending_nxt = 1'b0;
            end
        endcase
    end

    // Pending-A state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            a_pending <= 1'b0;
        else
            a_pending <= a_pending_nxt;
    end

endmodule

// File: rtl/iq_lane_regs.sv
// Module: iq_lane_regs
// Holds the pending A word and the two output registers plus the pair strobe.
// Assumes: load_a and emit_pair are never both set in the same cycle, and
// pass_thru takes priority over both.
module iq_lane_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_thru,
    input  logic              load_a,
    input  logic              emit_pair,
    input  logic [DATA_W-1:0] bus_a,
    input  logic [DATA_W-1:0] bus_b,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b,
    output logic              pair_vld
);

    logic [DATA_W-1:0] hold_a;

    // Capture the A word that waits for its B partner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_a <= '0;
        else if (load_a)
            hold_a <= bus_a;
    end

    // Update the output pair and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a    <= '0;
            out_b    <= '0;
            pair_vld <= 1'b0;
        end else if (pass_thru) begin
            out_a    <= bus_a;
            out_b    <= bus_b;
            pair_vld <= 1'b1;
        end else if (emit_pair) begin
            out_a    <= hold_a;
            out_b    <= bus_a;
            pair_vld <= 1'b1;
        end else begin
            pair_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/iq_bus_splitter.sv
// Module: iq_bus_splitter (top)
// Splits an interleaved I/Q word stream into time-aligned A/B channels, or
// passes two separate buses straight through.
// Assumes: one word per clock on bus_a; synchronous active-low reset.
module iq_bus_splitter
    import iq_split_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_interleave,
    input  logic              cfg_flag_sync,
    input  logic              tx_en,
    input  logic              word_flag,
    input  logic [DATA_W-1:0] bus_a,
    input  logic [DATA_W-1:0] bus_b,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b,
    output logic              pair_vld
);

    split_mode_e mode;
    logic        load_a;
    logic        emit_pair;

    // Decode the configuration bits into an operating mode.
    always_comb mode = pick_mode(cfg_interleave, cfg_flag_sync);

    iq_phase_ctl u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .tx_en     (tx_en),
        .word_flag (word_flag),
        .load_a    (load_a),
        .emit_pair (emit_pair)
    );

    iq_lane_regs #(.DATA_W(DATA_W)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .pass_thru (mode == MODE_PASS),
        .load_a    (load_a),
        .emit_pair (emit_pair),
        .bus_a     (bus_a),
        .bus_b     (bus_b),
        .out_a     (out_a),
        .out_b     (out_b),
        .pair_vld  (pair_vld)
    );

endmodule

// File: rtl/iq_bus_splitter_chk.sv
// Module: iq_bus_splitter_chk
// Temporal checks on the splitter's ports, attached to the top by bind.
// Assumes: synchronous active-low reset; properties are off while it is low.
module iq_bus_splitter_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_interleave,
    input logic              cfg_flag_sync,
    input logic              tx_en,
    input logic              word_flag,
    input logic [DATA_W-1:0] bus_a,
    input logic [DATA_W-1:0] bus_b,
    input logic [DATA_W-1:0] out_a,
    input logic [DATA_W-1:0] out_b,
    input logic              pair_vld
);

    // R2
    pass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_interleave |=> pair_vld && out_a == $past(bus_a) && out_b == $past(bus_b));

    // R3
    burst_first_is_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_interleave && !cfg_flag_sync && $rose(tx_en) |=> !pair_vld);

    // R4
    half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_interleave && $past(cfg_interleave) |=> !(pair_vld && $past(pair_vld)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_interleave && !cfg_flag_sync && !tx_en |=> !pair_vld && $stable(out_a) && $stable(out_b));

    // R6
    flag_a_no_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_interleave && cfg_flag_sync && !word_flag |=> !pair_vld);

    // R10
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_vld |-> $stable(out_a) && $stable(out_b));

endmodule

bind iq_bus_splitter iq_bus_splitter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_interleave (cfg_interleave),
    .cfg_flag_sync  (cfg_flag_sync),
    .tx_en          (tx_en),
    .word_flag      (word_flag),
    .bus_a          (bus_a),
    .bus_b          (bus_b),
    .out_a          (out_a),
    .out_b          (out_b),
    .pair_vld       (pair_vld)
);

// File: tb/sim_iq_bus_splitter.sv
module sim_iq_bus_splitter;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_interleave, cfg_flag_sync, tx_en, word_flag;
    logic [DW-1:0] bus_a, bus_b;
    logic [DW-1:0] out_a, out_b;
    logic          pair_vld;

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_a = '0;
    logic [DW-1:0] exp_b = '0;

    always #4 clk = ~clk;

    iq_bus_splitter #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_interleave(cfg_interleave),
        .cfg_flag_sync(cfg_flag_sync), .tx_en(tx_en), .word_flag(word_flag),
        .bus_a(bus_a), .bus_b(bus_b), .out_a(out_a), .out_b(out_b),
        .pair_vld(pair_vld)
    );

    task automatic check(input string req, input logic exp_v);
        n_cmp++;
        if (out_a !== exp_a || out_b !== exp_b || pair_vld !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got a=%h b=%h v=%b, expected a=%h b=%h v=%b",
                     req, out_a, out_b, pair_vld, exp_a, exp_b, exp_v);
        end
    endtask

    // Inputs are set at a falling edge; one rising edge later they are sampled at the next falling edge.
    task automatic step(input logic te, input logic fl, input logic [DW-1:0] wa, input logic [DW-1:0] wb);
        tx_en = te; word_flag = fl; bus_a = wa; bus_b = wb;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog: got hang, expected completion");
        finish_run();
    end

    initial begin
        logic          pend;
        logic [DW-1:0] pval;
        logic [DW-1:0] w;
        rst_n = 1'b0; cfg_interleave = 1'b1; cfg_flag_sync = 1'b0;
        tx_en = 1'b0; word_flag = 1'b0; bus_a = 16'hFFFF; bus_b = 16'hFFFF;
        @(negedge clk);
        step(1'b1, 1'b0, 16'hAAAA, 16'h5555);
        step(1'b1, 1'b1, 16'hBBBB, 16'h6666);
        // R1: reset clears outputs and strobe
        check("R1", 1'b0);
        rst_n = 1'b1;

        // R2: pass-through sweep
        cfg_interleave = 1'b0;
        for (int i = 0; i < 40; i++) begin
            step(i[0], i[1], DW'(i * 257 + 3), DW'(16'hF000 - i * 13));
            exp_a = DW'(i * 257 + 3);
            exp_b = DW'(16'hF000 - i * 13);
            check("R2", 1'b1);
        end

        // R3/R4/R5: transmit-enable bursts of length 1..9
        cfg_interleave = 1'b1; cfg_flag_sync = 1'b0;
        step(1'b0, 1'b0, 16'h0BAD, 16'h0BAD);
        check("R5", 1'b0);
        for (int len = 1; len <= 9; len++) begin
            for (int k = 0; k < len; k++) begin
                w = DW'(len * 16'h0100 + k);
                step(1'b1, k[0], w, ~w);
                if (k[0]) begin
                    exp_a = DW'(len * 16'h0100 + k - 1);
                    exp_b = w;
                    check((k == 1) ? "R3" : "R4", 1'b1);
                end else begin
                    check((k == 0) ? "R3" : "R4", 1'b0);
                end
            end
            for (int g = 0; g < 2; g++) begin
                step(1'b0, g[0], DW'(16'hDEAD + g + len), 16'hBEEF);
                check("R5", 1'b0);
            end
        end

        // R6/R7/R8/R9: every 6-word flag pattern, tx_en toggling
        for (int p = 0; p < 64; p++) begin
            cfg_interleave = 1'b0;
            step(1'b0, 1'b0, DW'(p), DW'(p + 1000));
            exp_a = DW'(p); exp_b = DW'(p + 1000);
            check("R2", 1'b1);
            cfg_interleave = 1'b1; cfg_flag_sync = 1'b1;
            pend = 1'b0; pval = '0;
            for (int k = 0; k < 6; k++) begin
                logic fl;
                logic v;
                string tag;
                fl = p[k];
                w  = DW'(16'h4000 + p * 8 + k);
                step(((p + k) % 3) == 0, fl, w, ~w);
                v = 1'b0;
                if (!fl) begin
                    tag  = pend ? "R7" : "R6";
                    pend = 1'b1; pval = w;
                end else if (pend) begin
                    tag   = "R6";
                    exp_a = pval; exp_b = w; v = 1'b1;
                    pend  = 1'b0;
                end else begin
                    tag = "R8";
                end
                if (k == 5) tag = "R9";
                check(tag, v);
            end
        end

        // R10: strobe low keeps outputs after a burst stops mid-pair
        cfg_flag_sync = 1'b0;
        step(1'b1, 1'b0, 16'h7777, 16'h0);
        check("R10", 1'b0);
        step(1'b0, 1'b0, 16'h8888, 16'h0);
        check("R10", 1'b0);

        finish_run();
    end

endmodule